// File: doc/BRIEF.md
# Periodic Auto-Reload Timer

This block is a memory-mapped counter that produces a periodic or single-shot interrupt. Software programs a start value into a load register, then sets bits in a control/status word. Those bits choose the count direction and turn on automatic reload, the interrupt enable and the timer itself. A load bit in the same word forces the counter to the start value for as long as it is held. Counting begins on the first clock after the load bit is released.

A count-down run expires when the counter leaves zero. A count-up run expires when the counter leaves the all-ones value. Every expiry sets the interrupt flag. With automatic reload on, the counter takes the start value again, so the period is the start value plus one clock in down mode. With automatic reload off, the counter holds its terminal value and the timer-enable bit clears itself. The flag is cleared by writing a 1 to its bit, so writing back the word just read acknowledges the interrupt. The interrupt line is the flag masked by the interrupt enable.

Top module: `art_timer`

## Requirements
- R1: After reset the control/status word, the load register and the counter all read zero, and `irq` is low.
- R2: The control/status word is at byte offset 0x00. Its bit positions are: bit 1 count down (0 = up), bit 4 auto-reload, bit 5 load, bit 6 interrupt enable, bit 7 timer enable, bit 8 interrupt flag. Bits 1, 4, 5, 6 and 7 read back what was last written. All other bits read zero and ignore writes.
- R3: The load register at offset 0x04 reads back the last value written. The counter at offset 0x08 is read-only, and writes to it leave it unchanged.
- R4: While the load bit is 1, the counter takes the load register value on every clock. This starts one clock after the write that sets the bit.
- R5: The counter changes by exactly one per clock only while timer enable is 1 and load is 0. Otherwise it holds.
- R6: In down mode, a clock with the counter at 0 is an expiry. With auto-reload the counter then takes the load value, and the flag is set on the same clock edge.
- R7: In up mode, a clock with the counter at all ones is an expiry. It has the same reload and flag behaviour as R6.
- R8: On an expiry without auto-reload, the counter keeps its terminal value and timer enable clears, unless a control write on that same clock sets it.
- R9: Writing 1 to bit 8 clears the flag. Writing 0 there leaves it unchanged. An expiry on the same clock as a clearing write leaves the flag set.
- R10: `irq` is 1 exactly when both the flag and the interrupt enable are 1.
- R11: Reads at unmapped word offsets (0x0C) return zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (same cycle when READ_REG = 0) |
| irq | output | 1 | Interrupt request: flag masked by interrupt enable |

## Verification
Directed runs cover three cases. A short down-counting auto-reload period shows whether reload happens on the right edge. An up-count run that starts just below all ones stops at expiry, which separates stop-and-disable from wraparound. An acknowledge sequence writes the read-back word and then a word with a zero flag bit, which tells write-one-to-clear apart from plain write. Random control words, small and near-maximum load values, counter writes and unmapped writes are then mixed on every clock. This exercises load-hold, enable gating and flag races against a per-clock reference model. The register readback is compared on every cycle.

// File: rtl/art_pkg.sv
package art_pkg;
   // word index of each register (byte offset >> 2)
   localparam int unsigned WIX_CTRL  = 0;
   localparam int unsigned WIX_LOAD  = 1;
   localparam int unsigned WIX_COUNT = 2;

   // control/status bit positions (software decodes these)
   localparam int unsigned BIT_DOWN = 1;
   localparam int unsigned BIT_ARL  = 4;
   localparam int unsigned BIT_LD   = 5;
   localparam int unsigned BIT_IE   = 6;
   localparam int unsigned BIT_EN   = 7;
   localparam int unsigned BIT_FLAG = 8;
   localparam int unsigned CTRL_USED_W = BIT_FLAG + 1;

   typedef struct packed {
      logic down;
      logic arl;
      logic ld;
      logic ie;
      logic en;
   } art_ctl_t;
endpackage

// File: rtl/art_ctrl.sv
module art_ctrl
   import art_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          expire,
   input  logic          stop,
   output art_ctl_t      ctl,
   output logic          flag
);
   logic unused_bits;
   assign unused_bits = ^{wdata[DW-1:CTRL_USED_W], wdata[3:2], wdata[0]};

   logic ack;
   assign ack = wr & wdata[BIT_FLAG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl  <= '0;
         flag <= 1'b0;
      end else begin
         if (wr) begin
            ctl.down <= wdata[BIT_DOWN];
            ctl.arl  <= wdata[BIT_ARL];
            ctl.ld   <= wdata[BIT_LD];
            ctl.ie   <= wdata[BIT_IE];
            ctl.en   <= wdata[BIT_EN];
         end else if (stop) begin
            ctl.en <= 1'b0;
         end
         // expiry wins over a same-cycle acknowledge
         flag <= expire | (flag & ~ack);
      end
   end

   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag);
   assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !expire) |=> !flag);
   assert_flag_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ack) |=> flag);
   assert_stop_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !wr) |=> !ctl.en);
endmodule

// File: rtl/art_count.sv
module art_count
   import art_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  art_ctl_t     ctl,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         expire
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   logic counting, at_end;
   assign counting = ctl.en & ~ctl.ld;
   assign at_end   = ctl.down ? (cnt == '0) : (cnt == ALL_ONES);
   assign expire   = counting & at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ctl.ld) begin
         cnt <= load_val;
      end else if (expire) begin
         if (ctl.arl) cnt <= load_val;
      end else if (counting) begin
         cnt <= ctl.down ? cnt - 1'b1 : cnt + 1'b1;
      end
   end

   assert_load_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.ld |=> cnt == $past(load_val));
   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.en && !ctl.ld) |=> $stable(cnt));
   assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && ctl.down && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
   assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && !ctl.down && cnt != ALL_ONES) |=> cnt == $past(cnt) + 1'b1);
   assert_reload_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && ctl.down && ctl.arl && cnt == '0) |=> cnt == $past(load_val));
   assert_reload_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && !ctl.down && ctl.arl && cnt == ALL_ONES) |=> cnt == $past(load_val));
   assert_terminal_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctl.arl) |=> $stable(cnt));
endmodule

// File: rtl/art_rdmux.sv
module art_rdmux
   import art_pkg::*;
#(
   parameter int unsigned W        = 32,
   parameter int unsigned WIX_W    = 2,
   parameter bit          READ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIX_W-1:0] wix,
   input  art_ctl_t         ctl,
   input  logic             flag,
   input  logic [W-1:0]     load_val,
   input  logic [W-1:0]     cnt,
   output logic [W-1:0]     rdata
);
   logic [W-1:0] status_word, sel_word;

   always_comb begin
      status_word           = '0;
      status_word[BIT_DOWN] = ctl.down;
      status_word[BIT_ARL]  = ctl.arl;
      status_word[BIT_LD]   = ctl.ld;
      status_word[BIT_IE]   = ctl.ie;
      status_word[BIT_EN]   = ctl.en;
      status_word[BIT_FLAG] = flag;
   end

   always_comb begin
      if (wix == WIX_W'(WIX_CTRL))       sel_word = status_word;
      else if (wix == WIX_W'(WIX_LOAD))  sel_word = load_val;
      else if (wix == WIX_W'(WIX_COUNT)) sel_word = cnt;
      else                               sel_word = '0;
   end

   generate
      if (READ_REG) begin : g_rd_flop
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= sel_word;
         end
      end else begin : g_rd_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rdata = sel_word;
      end
   endgenerate
endmodule

// File: rtl/art_timer.sv
module art_timer
   import art_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq
);
   localparam int unsigned WIX_W = ADDR_W - 2;

   generate
      if (CNT_W < CTRL_USED_W) begin : g_bad_width
         $error("art_timer: CNT_W must hold the control/status bits");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("art_timer: ADDR_W must reach three word registers");
      end
   endgenerate

   logic [WIX_W-1:0] wix;
   logic             unused_lsb;
   assign wix        = bus_addr[ADDR_W-1:2];
   assign unused_lsb = ^bus_addr[1:0];

   logic wr_ctrl, wr_load;
   assign wr_ctrl = bus_wr & (wix == WIX_W'(WIX_CTRL));
   assign wr_load = bus_wr & (wix == WIX_W'(WIX_LOAD));

   logic [CNT_W-1:0] load_q, cnt;
   art_ctl_t         ctl;
   logic             flag, expire, stop;

   always_ff @(posedge clk) begin
      if (!rst_n)       load_q <= '0;
      else if (wr_load) load_q <= bus_wdata;
   end

   assign stop = expire & ~ctl.arl;

   art_ctrl #(.DW(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(bus_wdata),
      .expire(expire), .stop(stop), .ctl(ctl), .flag(flag)
   );

   art_count #(.W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .load_val(load_q),
      .cnt(cnt), .expire(expire)
   );

   art_rdmux #(.W(CNT_W), .WIX_W(WIX_W), .READ_REG(READ_REG)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .wix(wix), .ctl(ctl), .flag(flag),
      .load_val(load_q), .cnt(cnt), .rdata(bus_rdata)
   );

   assign irq = flag & ctl.ie;

   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.ie |-> !irq);
   assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !flag |-> !irq);
   assert_load_untouched_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_load |=> $stable(load_q));
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (cnt == '0 && !flag && ctl == '0));
endmodule

// File: tb/art_timer_bench.sv
`timescale 1ns/100ps
module art_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   always #2 clk = ~clk;

   art_timer u_art_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   int tests = 0, fails = 0;
   bit done = 1'b0;

   // reference state
   logic [31:0] m_cnt = '0, m_load = '0;
   logic m_down = 0, m_arl = 0, m_ld = 0, m_ie = 0, m_en = 0, m_flag = 0;

   function automatic logic [31:0] status_exp();
      return {23'b0, m_flag, m_en, m_ie, m_ld, m_arl, 2'b00, m_down, 1'b0};
   endfunction

   task automatic model_step(input logic wr, input logic [3:0] a, input logic [31:0] d);
      logic counting, at_end, ex;
      logic [31:0] n_cnt;
      logic n_en, n_flag;
      counting = m_en && !m_ld;
      at_end   = m_down ? (m_cnt == 32'd0) : (m_cnt == 32'hFFFF_FFFF);
      ex       = counting && at_end;
      n_cnt = m_cnt;
      if (m_ld) n_cnt = m_load;
      else if (ex) begin if (m_arl) n_cnt = m_load; end
      else if (counting) n_cnt = m_down ? m_cnt - 1 : m_cnt + 1;
      n_en = m_en;
      if (ex && !m_arl) n_en = 1'b0;
      n_flag = m_flag;
      if (wr && a[3:2] == 2'd0 && d[8]) n_flag = 1'b0;
      if (ex) n_flag = 1'b1;
      if (wr && a[3:2] == 2'd0) begin
         m_down = d[1]; m_arl = d[4]; m_ld = d[5]; m_ie = d[6]; n_en = d[7];
      end
      if (wr && a[3:2] == 2'd1) m_load = d;
      m_cnt = n_cnt; m_en = n_en; m_flag = n_flag;
   endtask

   task automatic ck(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic peek(input logic [3:0] a, output logic [31:0] v);
      bus_addr = a;
      #0.2;
      v = bus_rdata;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] v;
      peek(4'h0, v); ck(tag, "status", v, status_exp());
      peek(4'h4, v); ck(tag, "load", v, m_load);
      peek(4'h8, v); ck(tag, "count", v, m_cnt);
      peek(4'hC, v); ck("R11", "unmapped", v, 32'd0);
      ck("R10", "irq", {31'b0, irq}, {31'b0, m_flag & m_ie});
   endtask

   // one clock; inputs driven at the falling edge, results sampled there
   task automatic tick(input string tag, input logic wr, input logic [3:0] a,
                       input logic [31:0] d);
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      model_step(wr, a, d);
      @(negedge clk);
      bus_wr = 1'b0;
      check_all(tag);
   endtask

   initial begin
      logic [31:0] rb;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");

      // R2: readback of implemented bits, others zero; flag untouched
      tick("R2", 1'b1, 4'h0, 32'hFFFF_FEFF);
      tick("R2", 1'b1, 4'h0, 32'h0000_0000);
      // R3: load register and read-only counter
      tick("R3", 1'b1, 4'h4, 32'h1234_5678);
      tick("R3", 1'b1, 4'h8, 32'hDEAD_BEEF);
      tick("R11", 1'b1, 4'hC, 32'hFFFF_FFFF);

      // R4..R6: down-count auto-reload with period load+1
      tick("R3", 1'b1, 4'h4, 32'd3);
      tick("R4", 1'b1, 4'h0, 32'h0000_0020);
      tick("R4", 1'b0, 4'h0, 32'h0);
      tick("R6", 1'b1, 4'h0, 32'h0000_00D2);
      for (int i = 0; i < 9; i++) tick("R6", 1'b0, 4'h0, 32'h0);

      // R9: write back read word acknowledges; zero in flag bit keeps it
      peek(4'h0, rb);
      tick("R9", 1'b1, 4'h0, rb);
      for (int i = 0; i < 4; i++) tick("R9", 1'b0, 4'h0, 32'h0);
      tick("R9", 1'b1, 4'h0, 32'h0000_00C0);
      tick("R9", 1'b0, 4'h0, 32'h0);
      tick("R9", 1'b1, 4'h0, 32'h0000_0140);

      // R7, R8: up count from near all ones, no auto-reload
      tick("R7", 1'b1, 4'h4, 32'hFFFF_FFFD);
      tick("R7", 1'b1, 4'h0, 32'h0000_0160);
      tick("R5", 1'b1, 4'h0, 32'h0000_0040);
      tick("R5", 1'b1, 4'h0, 32'h0000_00C0);
      for (int i = 0; i < 6; i++) tick("R8", 1'b0, 4'h0, 32'h0);

      // random mix
      for (int i = 0; i < 2000; i++) begin
         int unsigned op = $urandom_range(0, 9);
         logic [31:0] d;
         case (op)
            0, 1: begin
               d = $urandom & 32'h0000_01F2;
               if ($urandom_range(0, 3) != 0) d[5] = 1'b0;
               tick("R5", 1'b1, 4'h0, d);
            end
            2: begin
               d = ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 7))
                                               : 32'hFFFF_FFF8 | 32'($urandom_range(0, 7));
               tick("R3", 1'b1, 4'h4, d);
            end
            3: tick("R3", 1'b1, 4'h8, $urandom);
            4: tick("R11", 1'b1, 4'hC, $urandom);
            default: tick("R6", 1'b0, 4'h0, 32'h0);
         endcase
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule